// File: doc/BRIEF.md
# Asynchronous External Bus Controller

This block turns single accesses from an internal request port into timed cycles on a shared 16-bit external bus. The external bus connects to an asynchronous memory or peripheral. The external pins are chip-select, read-enable and write-enable, all active low, and an active-high address-latch strobe. The bus is split into an output value, a separate input value and two output-enable bits, one for each half. The pad ring or a wrapper can then build the tri-state pins, and each half can be released on its own.

Two modes exist:

- **Narrow mode:** the low byte of the address sits on the upper half of the bus. The data byte uses the lower half, with no multiplexing.
- **Multiplexed mode:** a full 16-bit address word is first placed on the whole bus, shifted right by one bit. It is framed by a one-cycle latch strobe. After that the same wires carry 16-bit data.

Every access walks through three programmable phases: setup, strobe and hold. Reads and writes each have their own three lengths. The mode and the lengths are taken from plain input ports at the moment a request is accepted.

The requester raises `req_valid` with a stable command. It holds the command until `req_ready` pulses for one cycle at the end of the access. For a read, `rsp_valid` pulses in the same cycle, and `rsp_rdata` carries the sampled word.

Top module: `xbus_bridge`

## Requirements
- R1: During reset and in the cycle after any reset, `cs_n`, `re_n` and `we_n` are 1. `ale`, `bus_oe_hi`, `bus_oe_lo`, `req_ready` and `rsp_valid` are 0. An access cut by reset is abandoned.
- R2: In narrow mode (`cfg_mux`=0), from the first access cycle to the last hold cycle, `bus_oe_hi`=1 and `bus_out[15:8]` equals `req_addr[7:0]`. For a read, `bus_oe_lo` stays 0 throughout.
- R3: In a narrow-mode write, `bus_oe_lo`=1 and `bus_out[7:0]` equals `req_wdata[7:0]` through setup, strobe and hold.
- R4: After acceptance, `cs_n` is 0 for P+S+T+H cycles. P is 2 in multiplexed mode and 0 in narrow mode, and S, T, H are the setup, strobe and hold lengths. The access strobe (`re_n` for reads, `we_n` for writes) is 0 for exactly the T cycles that follow P+S cycles. The other strobe stays 1.
- R5: Reads take S, T, H from `cfg_rd_setup`, `cfg_rd_strobe` and `cfg_rd_hold`. Writes take them from `cfg_wr_setup`, `cfg_wr_strobe` and `cfg_wr_hold`. The other set has no effect.
- R6: A strobe length of 0 is treated as 1 cycle. Setup and hold of 0 remove those phases.
- R7: In multiplexed mode (`cfg_mux`=1), the first access cycle has `ale`=1. The second cycle has `ale`=0. In both, both output enables are 1 and `bus_out` equals `req_addr >> 1`, so bus bit 0 carries address bit 1. `ale` is never high for two cycles in a row.
- R8: In multiplexed mode, after the two address cycles, a write drives `req_wdata` on all 16 bits with both enables at 1. A read keeps both enables at 0.
- R9: Read data is sampled from `bus_in` on the last strobe cycle. In multiplexed mode `rsp_rdata` is the full 16-bit word. In narrow mode it is `{8'h00, bus_in[7:0]}`.
- R10: In the cycle after the last access cycle, `req_ready` is 1 for exactly one cycle. `rsp_valid` is 1 in that cycle only for reads.
- R11: Changes on `cfg_*` after a request is accepted do not alter the ongoing access.
- R12: Whenever `cs_n` is 1, both bus output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_ready | output | 1 | One-cycle pulse when the access completes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| cfg_mux | input | 1 | 0 = narrow mode, 1 = multiplexed mode |
| cfg_rd_setup | input | 4 | Read setup cycles |
| cfg_rd_strobe | input | 4 | Read strobe cycles (0 acts as 1) |
| cfg_rd_hold | input | 4 | Read hold cycles |
| cfg_wr_setup | input | 4 | Write setup cycles |
| cfg_wr_strobe | input | 4 | Write strobe cycles (0 acts as 1) |
| cfg_wr_hold | input | 4 | Write hold cycles |
| bus_in | input | 16 | Value seen on the external bus |
| bus_out | output | 16 | Value driven on the external bus |
| bus_oe_hi | output | 1 | Output enable for bus bits 15:8 |
| bus_oe_lo | output | 1 | Output enable for bus bits 7:0 |
| cs_n | output | 1 | Chip select, active low |
| re_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| ale | output | 1 | Address latch enable, active high |

## Verification
The assertions assume the following about the requester:

- It keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` steady from the request until the `req_ready` pulse.
- It drops `req_valid` before the controller returns to idle.

The bench keeps to these assumptions by raising and lowering the request only at falling edges, and only in those windows. The `cfg_*` ports are free to move at any time, and the bench deliberately scrambles them one cycle into some accesses.

`bus_in` is assumed to matter only during a read strobe. The bench drives a different word in each strobe cycle and a fixed filler outside the strobe. This shows that exactly the last strobe cycle is captured.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Phase of the external access; ALE and AHOLD occur only in multiplexed mode.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_AHOLD  = 3'd2,
    PH_SETUP  = 3'd3,
    PH_STROBE = 3'd4,
    PH_HOLD   = 3'd5,
    PH_DONE   = 3'd6
  } xbus_phase_e;

endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

  // R4: an expired counter stays expired until reloaded
  a_r4_timer_rests: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             cfg_mux,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_rd_strobe,
  input  logic [CNT_W-1:0] cfg_rd_hold,
  input  logic [CNT_W-1:0] cfg_wr_setup,
  input  logic [CNT_W-1:0] cfg_wr_strobe,
  input  logic [CNT_W-1:0] cfg_wr_hold,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             t_last,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output xbus_phase_e      ph_nxt,
  output logic             eff_write,
  output logic             eff_mux,
  output logic [BUS_W-1:0] eff_addr,
  output logic [BUS_W-1:0] eff_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata
);

  localparam int HALF = BUS_W / 2;

  xbus_phase_e      st;
  logic             accept;
  logic             cap_write, cap_mux;
  logic [BUS_W-1:0] cap_addr, cap_wdata;
  logic [CNT_W-1:0] cap_setup, cap_strobe, cap_hold;
  logic [CNT_W-1:0] sel_setup, sel_strobe, sel_hold;
  logic [CNT_W-1:0] eff_setup, eff_strobe, eff_hold;

  assign accept = (st == PH_IDLE) && req_valid;

  always_comb begin
    sel_setup  = req_write ? cfg_wr_setup  : cfg_rd_setup;
    sel_strobe = req_write ? cfg_wr_strobe : cfg_rd_strobe;
    sel_hold   = req_write ? cfg_wr_hold   : cfg_rd_hold;
    if (sel_strobe == '0) sel_strobe = {{(CNT_W-1){1'b0}}, 1'b1};
  end

  // Values that govern the current cycle: fresh on acceptance, captured after.
  assign eff_write  = accept ? req_write  : cap_write;
  assign eff_mux    = accept ? cfg_mux    : cap_mux;
  assign eff_addr   = accept ? req_addr   : cap_addr;
  assign eff_wdata  = accept ? req_wdata  : cap_wdata;
  assign eff_setup  = accept ? sel_setup  : cap_setup;
  assign eff_strobe = accept ? sel_strobe : cap_strobe;
  assign eff_hold   = accept ? sel_hold   : cap_hold;

  always_comb begin
    ph_nxt = st;
    case (st)
      PH_IDLE: begin
        if (req_valid) begin
          if (eff_mux)               ph_nxt = PH_ALE;
          else if (eff_setup != '0)  ph_nxt = PH_SETUP;
          else                       ph_nxt = PH_STROBE;
        end
      end
      PH_ALE:    ph_nxt = PH_AHOLD;
      PH_AHOLD:  ph_nxt = (eff_setup != '0) ? PH_SETUP : PH_STROBE;
      PH_SETUP:  if (t_last) ph_nxt = PH_STROBE;
      PH_STROBE: if (t_last) ph_nxt = (eff_hold != '0) ? PH_HOLD : PH_DONE;
      PH_HOLD:   if (t_last) ph_nxt = PH_DONE;
      PH_DONE:   ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    t_load = (ph_nxt != st) &&
             (ph_nxt == PH_SETUP || ph_nxt == PH_STROBE || ph_nxt == PH_HOLD);
    case (ph_nxt)
      PH_SETUP:  t_val = eff_setup  - 1'b1;
      PH_STROBE: t_val = eff_strobe - 1'b1;
      PH_HOLD:   t_val = eff_hold   - 1'b1;
      default:   t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cap_write  <= 1'b0;
      cap_mux    <= 1'b0;
      cap_addr   <= '0;
      cap_wdata  <= '0;
      cap_setup  <= '0;
      cap_strobe <= '0;
      cap_hold   <= '0;
      rsp_rdata  <= '0;
      req_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      st <= ph_nxt;
      if (accept) begin
        cap_write  <= req_write;
        cap_mux    <= cfg_mux;
        cap_addr   <= req_addr;
        cap_wdata  <= req_wdata;
        cap_setup  <= sel_setup;
        cap_strobe <= sel_strobe;
        cap_hold   <= sel_hold;
      end
      if (st == PH_STROBE && t_last && !cap_write) begin
        rsp_rdata <= cap_mux ? bus_in : {{HALF{1'b0}}, bus_in[HALF-1:0]};
      end
      req_ready <= (ph_nxt == PH_DONE);
      rsp_valid <= (ph_nxt == PH_DONE) && !eff_write;
    end
  end

  // R10: completion is a single-cycle pulse, and a response implies completion
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
  a_r10_rsp_with_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
  // R6: a captured strobe length is never zero while strobing
  a_r6_strobe_nonzero: assert property (@(posedge clk) disable iff (rst)
    (st == PH_STROBE) |-> (cap_strobe != '0));
  // R4: hold is only reached from strobe
  a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD) |-> ($past(st) == PH_STROBE || $past(st) == PH_HOLD));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  xbus_phase_e      ph,
  input  logic             write,
  input  logic             mux,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe_hi,
  output logic             bus_oe_lo,
  output logic             cs_n,
  output logic             re_n,
  output logic             we_n,
  output logic             ale
);

  localparam int HALF = BUS_W / 2;

  logic [BUS_W-1:0] n_bus;
  logic             n_oe_hi, n_oe_lo;
  logic             addr_ph, data_ph;

  assign addr_ph = (ph == PH_ALE) || (ph == PH_AHOLD);
  assign data_ph = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);

  always_comb begin
    n_bus   = '0;
    n_oe_hi = 1'b0;
    n_oe_lo = 1'b0;
    if (addr_ph) begin
      n_bus   = addr >> 1;
      n_oe_hi = 1'b1;
      n_oe_lo = 1'b1;
    end else if (data_ph) begin
      if (mux) begin
        if (write) begin
          n_bus   = wdata;
          n_oe_hi = 1'b1;
          n_oe_lo = 1'b1;
        end
      end else begin
        n_bus[BUS_W-1:HALF] = addr[HALF-1:0];
        n_oe_hi             = 1'b1;
        if (write) begin
          n_bus[HALF-1:0] = wdata[HALF-1:0];
          n_oe_lo         = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out   <= '0;
      bus_oe_hi <= 1'b0;
      bus_oe_lo <= 1'b0;
      cs_n      <= 1'b1;
      re_n      <= 1'b1;
      we_n      <= 1'b1;
      ale       <= 1'b0;
    end else begin
      bus_out   <= n_bus;
      bus_oe_hi <= n_oe_hi;
      bus_oe_lo <= n_oe_lo;
      cs_n      <= !(addr_ph || data_ph);
      re_n      <= !((ph == PH_STROBE) && !write);
      we_n      <= !((ph == PH_STROBE) && write);
      ale       <= (ph == PH_ALE);
    end
  end

  // R7: latch strobe lasts one cycle and sits inside a selected access
  a_r7_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  a_r7_ale_selected: assert property (@(posedge clk) disable iff (rst)
    ale |-> (!cs_n && bus_oe_hi && bus_oe_lo));
  // R12: bus released outside an access
  a_r12_idle_release: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!bus_oe_hi && !bus_oe_lo));
  // R2: read strobe never drives the low half
  a_r2_read_lo_free: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> (!bus_oe_lo && !cs_n));
  // R3: write strobe always has data driven
  a_r3_write_drives: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (bus_oe_lo && !cs_n));
  // R4: read and write strobes are exclusive
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!re_n && !we_n));

endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  input  logic             cfg_mux,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_rd_strobe,
  input  logic [CNT_W-1:0] cfg_rd_hold,
  input  logic [CNT_W-1:0] cfg_wr_setup,
  input  logic [CNT_W-1:0] cfg_wr_strobe,
  input  logic [CNT_W-1:0] cfg_wr_hold,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe_hi,
  output logic             bus_oe_lo,
  output logic             cs_n,
  output logic             re_n,
  output logic             we_n,
  output logic             ale
);

  logic             t_load, t_last;
  logic [CNT_W-1:0] t_val;
  xbus_phase_e      ph_nxt;
  logic             eff_write, eff_mux;
  logic [BUS_W-1:0] eff_addr, eff_wdata;

  xbus_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  xbus_seq #(.BUS_W(BUS_W), .CNT_W(CNT_W)) i_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .cfg_mux       (cfg_mux),
    .cfg_rd_setup  (cfg_rd_setup),
    .cfg_rd_strobe (cfg_rd_strobe),
    .cfg_rd_hold   (cfg_rd_hold),
    .cfg_wr_setup  (cfg_wr_setup),
    .cfg_wr_strobe (cfg_wr_strobe),
    .cfg_wr_hold   (cfg_wr_hold),
    .bus_in        (bus_in),
    .t_last        (t_last),
    .t_load        (t_load),
    .t_val         (t_val),
    .ph_nxt        (ph_nxt),
    .eff_write     (eff_write),
    .eff_mux       (eff_mux),
    .eff_addr      (eff_addr),
    .eff_wdata     (eff_wdata),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata)
  );

  xbus_pins #(.BUS_W(BUS_W)) i_pins (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph_nxt),
    .write     (eff_write),
    .mux       (eff_mux),
    .addr      (eff_addr),
    .wdata     (eff_wdata),
    .bus_out   (bus_out),
    .bus_oe_hi (bus_oe_hi),
    .bus_oe_lo (bus_oe_lo),
    .cs_n      (cs_n),
    .re_n      (re_n),
    .we_n      (we_n),
    .ale       (ale)
  );

  // R1: strobes and latch stay idle while selection is off
  a_r1_quiet_when_unselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (re_n && we_n && !ale));

endmodule

// File: tb/test_xbus_bridge.sv
module test_xbus_bridge;

  typedef struct packed {
    logic        mux;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [3:0]  su;
    logic [3:0]  st;
    logic [3:0]  ho;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0034, 16'h0000, 4'd2,  4'd3,  4'd1,  16'h1234},
    '{1'b0, 1'b1, 16'h00C5, 16'h00A7, 4'd1,  4'd2,  4'd2,  16'h0000},
    '{1'b1, 1'b0, 16'hABCD, 16'h0000, 4'd0,  4'd1,  4'd0,  16'h5A3C},
    '{1'b1, 1'b1, 16'h8001, 16'hFACE, 4'd3,  4'd4,  4'd2,  16'h0000},
    '{1'b0, 1'b0, 16'h00FF, 16'h0000, 4'd0,  4'd1,  4'd0,  16'h00E1},
    '{1'b1, 1'b0, 16'h7FFE, 16'h0000, 4'd2,  4'd5,  4'd3,  16'hC001},
    '{1'b0, 1'b1, 16'h0000, 16'h00FF, 4'd0,  4'd1,  4'd0,  16'h0000},
    '{1'b1, 1'b1, 16'hFFFF, 16'h0001, 4'd15, 4'd15, 4'd15, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cfg_mux = 1'b0;
  logic [3:0]  cfg_rd_setup = '0, cfg_rd_strobe = 4'd1, cfg_rd_hold = '0;
  logic [3:0]  cfg_wr_setup = '0, cfg_wr_strobe = 4'd1, cfg_wr_hold = '0;
  logic [15:0] bus_in, bus_out;
  logic        bus_oe_hi, bus_oe_lo, cs_n, re_n, we_n, ale;
  logic [15:0] rd_base = '0;
  logic [15:0] stb_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // Device model: a different word in each strobe cycle, filler elsewhere.
  always_ff @(posedge clk) begin
    if (cs_n) stb_idx <= '0;
    else if (!re_n) stb_idx <= stb_idx + 16'd1;
  end
  assign bus_in = !re_n ? (rd_base + stb_idx) : 16'hA5A5;

  xbus_bridge i_xbus_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_mux(cfg_mux),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe_hi(bus_oe_hi), .bus_oe_lo(bus_oe_lo),
    .cs_n(cs_n), .re_n(re_n), .we_n(we_n), .ale(ale)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "cs_n", cs_n, 1'b1);
    chk(tag, "re_n/we_n/ale", {re_n, we_n, ale}, 3'b110);
    chk(tag, "oe", {bus_oe_hi, bus_oe_lo}, 2'b00);
    chk(tag, "ready/rsp", {req_ready, rsp_valid}, 2'b00);
  endtask

  task automatic run_access(input vec_t v, input bit scramble, input string tag);
    int pre, s, t, h, n;
    logic [15:0] exp_rd;
    pre = v.mux ? 2 : 0;
    s = int'(v.su);
    t = (v.st == 4'd0) ? 1 : int'(v.st);
    h = int'(v.ho);
    n = pre + s + t + h;
    exp_rd = v.rd + 16'(t - 1);
    if (!v.mux) exp_rd = {8'h00, exp_rd[7:0]};
    @(negedge clk);
    cfg_mux = v.mux;
    if (v.wr) begin
      {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {v.su, v.st, v.ho};
      {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {4'd9, 4'd9, 4'd9};
    end else begin
      {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {v.su, v.st, v.ho};
      {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {4'd6, 4'd7, 4'd5};
    end
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wdata;
    rd_base   = v.rd;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == 1 && scramble) begin
        cfg_mux = ~v.mux;
        {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {4'd7, 4'd0, 4'd7};
        {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {4'd0, 4'd7, 4'd0};
      end
      if (k <= n) begin
        bit in_stb;
        in_stb = (k > pre + s) && (k <= pre + s + t);
        chk(tag, "cs_n", cs_n, 1'b0);
        chk(tag, "ale R7", ale, v.mux && k == 1);
        chk(tag, "re_n", re_n, !(in_stb && !v.wr));
        chk(tag, "we_n", we_n, !(in_stb && v.wr));
        chk(tag, "ready early R10", req_ready, 1'b0);
        if (v.mux && k <= pre)
          chk("R7", "addr phase", {bus_oe_hi, bus_oe_lo, bus_out}, {2'b11, v.addr >> 1});
        else if (v.mux) begin
          if (v.wr) chk("R8", "mux wdata", {bus_oe_hi, bus_oe_lo, bus_out}, {2'b11, v.wdata});
          else      chk("R8", "mux read oe", {bus_oe_hi, bus_oe_lo}, 2'b00);
        end else begin
          chk("R2", "narrow addr", {bus_oe_hi, bus_out[15:8]}, {1'b1, v.addr[7:0]});
          if (v.wr) chk("R3", "narrow wdata", {bus_oe_lo, bus_out[7:0]}, {1'b1, v.wdata[7:0]});
          else      chk("R2", "narrow read lo oe", bus_oe_lo, 1'b0);
        end
      end else begin
        chk("R10", "ready", req_ready, 1'b1);
        chk("R10", "rsp_valid", rsp_valid, !v.wr);
        chk("R12", "released", {cs_n, bus_oe_hi, bus_oe_lo}, 3'b100);
        if (!v.wr) chk("R9", "rdata", rsp_rdata, exp_rd);
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk_idle("R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");

    // Table of vectors, timing tagged R4
    for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0, "R4");

    // R5: read then write with distinct sets, the unused set differs
    run_access('{1'b0, 1'b0, 16'h0011, 16'h0000, 4'd1, 4'd2, 4'd1, 16'h0F0F}, 1'b0, "R5");
    run_access('{1'b0, 1'b1, 16'h0022, 16'h0033, 4'd3, 4'd1, 4'd2, 16'h0000}, 1'b0, "R5");

    // R6: strobe of zero behaves as one cycle
    run_access('{1'b0, 1'b0, 16'h0044, 16'h0000, 4'd1, 4'd0, 4'd1, 16'h3C3C}, 1'b0, "R6");
    run_access('{1'b1, 1'b1, 16'h1234, 16'hBEEF, 4'd0, 4'd0, 4'd0, 16'h0000}, 1'b0, "R6");

    // R11: configuration scrambled one cycle into the access
    run_access('{1'b0, 1'b0, 16'h0055, 16'h0000, 4'd2, 4'd3, 4'd2, 16'h2222}, 1'b1, "R11");
    run_access('{1'b1, 1'b1, 16'h4321, 16'h9876, 4'd1, 4'd2, 4'd1, 16'h0000}, 1'b1, "R11");

    // R1: reset in the middle of an access
    @(negedge clk);
    cfg_mux = 1'b0;
    {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {4'd4, 4'd4, 4'd4};
    req_write = 1'b0; req_addr = 16'h0066; req_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "mid access selected", cs_n, 1'b0);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    run_access(VECS[3], 1'b0, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule